// File: doc/BRIEF.md
# T1 Receive Alarm Pulse Generator

This block drives two alarm outputs of a T1 receive framer: a bipolar-violation indication and a frame-error indication. The line decoder, the framing-pattern checker and the CRC6 checker sit upstream. They hand this block one flag per bit time, and the block turns those flags into pulses of the correct width and timing. The violation output follows the serial data bit by bit. Line codes that a zero-substitution decoder recognises are screened out, so they are never reported as violations.

The frame-error output carries two different signals on one wire. The first is a framing-bit mismatch. This rises during the F-bit time and lasts two bit periods. Which F-bits count depends on the framing mode. In superframe mode every framing bit counts, and frame 12 can optionally be excluded. In extended-superframe mode only the pattern bits count, which means every fourth frame. The second signal is a CRC6 failure for the multiframe just ended. This is a single bit-period pulse that starts half a clock period before the multiframe sync rises. To produce that half-period lead, the frame-error logic updates on the falling clock edge. The violation logic updates on the rising edge.

Top module: `t1_rx_alarm_gen`

## Requirements
- R1: `viol_out` is high for the bit period that follows each rising clock edge at which `bit_viol` is sampled high, unless R2 masks it. It is low in the bit period after an edge where `bit_viol` is low, so back-to-back violations give a continuous high level.
- R2: When `zcs_en` is 1, a violation sampled together with `zcs_code` = 1 is not reported, and `viol_out` stays low for that bit. When `zcs_en` is 0, `zcs_code` has no effect.
- R3: A framing error qualifies only when `fbit_stb` and `fbit_err` are both sampled high at a falling edge. A qualifying error raises `frm_err_out` at that falling edge. The output stays high for exactly two bit periods, i.e. until the second following falling edge.
- R4: In superframe mode (`esf_mode` = 0) an error in any frame qualifies, subject to R5. In extended-superframe mode (`esf_mode` = 1) only frames whose 0-based `frame_idx` gives remainder 3 when divided by 4 qualify. Errors flagged in other frames have no effect on `frm_err_out`.
- R5: In superframe mode with `skip_f12` = 1, an error at `frame_idx` = 11 (frame twelve, counting frames 0 to 11) has no effect. With `skip_f12` = 0 it qualifies. `skip_f12` has no effect on other frames.
- R6: In extended-superframe mode, `crc_err` and `mf_due` sampled high together at a falling edge drive `frm_err_out` high for exactly one bit period, starting at that falling edge. `mf_due` marks the bit period just before the multiframe sync rises, so the pulse leads that rise by half a clock period. `crc_err` without `mf_due`, or `mf_due` without `crc_err`, has no effect.
- R7: In superframe mode, `crc_err` and `mf_due` have no effect on `frm_err_out`.
- R8: If a framing-error pulse and a CRC6 pulse overlap or touch, `frm_err_out` is the logical OR of the two pulses.
- R9: While `rst_n` is low, `viol_out` and `frm_err_out` are low whatever the other inputs do, and the pulse state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_viol | input | 1 | Violation flag for the bit about to appear on the serial output |
| zcs_en | input | 1 | Zero-substitution decoding enabled |
| zcs_code | input | 1 | Current violation belongs to a zero-substitution code |
| fbit_stb | input | 1 | High during the F-bit period of each frame |
| esf_mode | input | 1 | 0 = superframe, 1 = extended superframe |
| skip_f12 | input | 1 | Exclude frame-12 F-bit errors in superframe mode |
| frame_idx | input | 5 | 0-based frame number within the superframe or extended superframe |
| fbit_err | input | 1 | Received F-bit differs from the expected pattern |
| crc_err | input | 1 | CRC6 mismatch for the previous multiframe |
| mf_due | input | 1 | High during the bit period just before multiframe sync rises |
| viol_out | output | 1 | Bipolar-violation indication |
| frm_err_out | output | 1 | Frame-error indication (framing-bit and CRC6 pulses) |

## Verification
On every cycle, the assertions check that the violation output tracks the previous flag, that substitution codes are masked, and that a qualified framing error holds the frame-error output for two falling edges and then releases it. They also check that a CRC6 hit produces a high level, that superframe mode never lets the CRC path through, and that the frame-qualification logic rejects frame twelve when it is skipped and rejects non-pattern frames in extended-superframe mode. Other properties need a chosen scenario: the half-period lead relative to the rising edge, the OR of a framing pulse with a neighbouring CRC6 pulse, and the clean outputs under reset. The bench scenarios show these by sampling at points between the two clock edges.

// File: rtl/t1_alarm_pkg.sv
package t1_alarm_pkg;

    typedef enum logic {
        FRM_SF  = 1'b0,
        FRM_ESF = 1'b1
    } frm_mode_e;

endpackage

// File: rtl/t1_viol_shaper.sv
module t1_viol_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_viol,
    input  logic zcs_en,
    input  logic zcs_code,
    output logic viol_out
);

    typedef struct packed {
        logic hit;
    } vstate_t;

    vstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.hit = bit_viol && !(zcs_en && zcs_code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol_out = st_q.hit;

    // R1: an unmasked violation shows in the following bit period
    p_viol_shown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_viol && !zcs_code) |=> viol_out);

    // R1: no flag, no indication in the following bit period
    p_viol_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_viol |=> !viol_out);

    // R2: substitution codes are never reported while decoding is on
    p_zcs_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (zcs_en && zcs_code) |=> !viol_out);

endmodule

// File: rtl/t1_fe_qualify.sv
module t1_fe_qualify
    import t1_alarm_pkg::*;
#(
    parameter int unsigned FRM_IDX_W  = 5,
    parameter int unsigned SF_FRAMES  = 12,
    parameter int unsigned FPS_PERIOD = 4
) (
    input  logic                 fbit_stb,
    input  logic                 fbit_err,
    input  logic                 esf_mode,
    input  logic                 skip_f12,
    input  logic [FRM_IDX_W-1:0] frame_idx,
    output logic                 fe_hit
);

    localparam int unsigned PHASE_W = (FPS_PERIOD > 1) ? $clog2(FPS_PERIOD) : 1;
    localparam bit          POW2    = (FPS_PERIOD & (FPS_PERIOD - 1)) == 0;

    frm_mode_e mode;
    logic      fps_slot;
    logic      last_sf;

    assign mode    = frm_mode_e'(esf_mode);
    assign last_sf = 32'(frame_idx) == (SF_FRAMES - 1);

    generate
        if (POW2) begin : g_mask
            assign fps_slot = frame_idx[PHASE_W-1:0] == PHASE_W'(FPS_PERIOD - 1);
        end else begin : g_mod
            assign fps_slot = (32'(frame_idx) % FPS_PERIOD) == (FPS_PERIOD - 1);
        end
    endgenerate

    always_comb begin
        fe_hit = 1'b0;
        if (fbit_stb && fbit_err) begin
            case (mode)
                FRM_ESF: fe_hit = fps_slot;
                default: fe_hit = !(skip_f12 && last_sf);
            endcase
        end
    end

endmodule

// File: rtl/t1_fe_shaper.sv
module t1_fe_shaper #(
    parameter int unsigned FE_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fe_hit,
    input  logic esf_mode,
    input  logic crc_err,
    input  logic mf_due,
    output logic frm_err_out
);

    localparam int unsigned CW = $clog2(FE_BITS + 1);

    typedef struct packed {
        logic [CW-1:0] rem;
        logic          crc;
    } fstate_t;

    fstate_t st_d, st_q;
    logic    crc_hit;

    assign crc_hit = esf_mode && mf_due && crc_err;

    always_comb begin
        st_d = st_q;
        if (fe_hit)              st_d.rem = CW'(FE_BITS);
        else if (st_q.rem != '0) st_d.rem = st_q.rem - 1'b1;
        st_d.crc = crc_hit;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frm_err_out = (st_q.rem != '0) || st_q.crc;

    // R3: a qualified error holds the output over two falling edges
    p_fe_hold_r3: assert property (@(negedge clk) disable iff (!rst_n)
        fe_hit |=> frm_err_out ##1 frm_err_out);

    // R3: the pulse ends after its last bit when nothing new arrives
    p_fe_end_r3: assert property (@(negedge clk) disable iff (!rst_n)
        (st_q.rem == CW'(1) && !fe_hit && !crc_hit) |=> !frm_err_out);

    // R6: CRC6 hit in extended mode produces a high level at once
    p_crc_pulse_r6: assert property (@(negedge clk) disable iff (!rst_n)
        (esf_mode && mf_due && crc_err) |=> frm_err_out);

    // R7: superframe mode keeps the CRC path silent
    p_sf_crc_quiet_r7: assert property (@(negedge clk) disable iff (!rst_n)
        (!esf_mode && !fe_hit && st_q.rem == '0) |=> !frm_err_out);

endmodule

// File: rtl/t1_rx_alarm_gen.sv
module t1_rx_alarm_gen #(
    parameter int unsigned FRM_IDX_W  = 5,
    parameter int unsigned SF_FRAMES  = 12,
    parameter int unsigned FPS_PERIOD = 4,
    parameter int unsigned FE_BITS    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_viol,
    input  logic                 zcs_en,
    input  logic                 zcs_code,
    input  logic                 fbit_stb,
    input  logic                 esf_mode,
    input  logic                 skip_f12,
    input  logic [FRM_IDX_W-1:0] frame_idx,
    input  logic                 fbit_err,
    input  logic                 crc_err,
    input  logic                 mf_due,
    output logic                 viol_out,
    output logic                 frm_err_out
);

    logic fe_hit;

    t1_viol_shaper u_viol (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_viol (bit_viol),
        .zcs_en   (zcs_en),
        .zcs_code (zcs_code),
        .viol_out (viol_out)
    );

    t1_fe_qualify #(
        .FRM_IDX_W  (FRM_IDX_W),
        .SF_FRAMES  (SF_FRAMES),
        .FPS_PERIOD (FPS_PERIOD)
    ) u_qual (
        .fbit_stb  (fbit_stb),
        .fbit_err  (fbit_err),
        .esf_mode  (esf_mode),
        .skip_f12  (skip_f12),
        .frame_idx (frame_idx),
        .fe_hit    (fe_hit)
    );

    t1_fe_shaper #(
        .FE_BITS (FE_BITS)
    ) u_fe (
        .clk         (clk),
        .rst_n       (rst_n),
        .fe_hit      (fe_hit),
        .esf_mode    (esf_mode),
        .crc_err     (crc_err),
        .mf_due      (mf_due),
        .frm_err_out (frm_err_out)
    );

    // R4: in extended mode only pattern frames may qualify
    p_esf_fps_only_r4: assert property (@(negedge clk) disable iff (!rst_n)
        (esf_mode && (32'(frame_idx) % FPS_PERIOD) != (FPS_PERIOD - 1)) |-> !fe_hit);

    // R5: frame twelve is rejected in superframe mode when skipped
    p_f12_skip_r5: assert property (@(negedge clk) disable iff (!rst_n)
        (!esf_mode && skip_f12 && 32'(frame_idx) == (SF_FRAMES - 1)) |-> !fe_hit);

    // R3: no qualification outside the F-bit time
    p_fe_needs_stb_r3: assert property (@(negedge clk) disable iff (!rst_n)
        !fbit_stb |-> !fe_hit);

endmodule

// File: tb/sim_t1_rx_alarm_gen.sv
module sim_t1_rx_alarm_gen;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_viol = 1'b0, zcs_en = 1'b0, zcs_code = 1'b0;
    logic       fbit_stb = 1'b0, esf_mode = 1'b0, skip_f12 = 1'b0;
    logic [4:0] frame_idx = '0;
    logic       fbit_err = 1'b0, crc_err = 1'b0, mf_due = 1'b0;
    logic       viol_out, frm_err_out;

    t1_rx_alarm_gen u0 (
        .clk(clk), .rst_n(rst_n), .bit_viol(bit_viol), .zcs_en(zcs_en),
        .zcs_code(zcs_code), .fbit_stb(fbit_stb), .esf_mode(esf_mode),
        .skip_f12(skip_f12), .frame_idx(frame_idx), .fbit_err(fbit_err),
        .crc_err(crc_err), .mf_due(mf_due), .viol_out(viol_out),
        .frm_err_out(frm_err_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        bit    v;
        bit    f;
        string tag;
    } exp_t;

    exp_t queue_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    bit   cfg_zen = 1'b0, cfg_esf = 1'b0, cfg_skip = 1'b0;
    int   m_rem = 0;

    task automatic chk(input bit act, input bit exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: %s = %0b, expected %0b", tag, what, act, exp);
        end
    endtask

    // driver: applies one bit period of stimulus and queues the expected outputs
    task automatic drive_bit(input bit v, input bit zc, input bit fs, input bit fe,
                             input int idx, input bit crc, input bit due, input string tag);
        exp_t e;
        bit   qual, crc_h;
        @(posedge clk);
        #1;
        bit_viol = v; zcs_code = zc; fbit_stb = fs; fbit_err = fe;
        frame_idx = 5'(idx); crc_err = crc; mf_due = due;
        zcs_en = cfg_zen; esf_mode = cfg_esf; skip_f12 = cfg_skip;
        qual  = fs && fe && (cfg_esf ? ((idx % 4) == 3) : !(cfg_skip && idx == 11));
        crc_h = cfg_esf && due && crc;
        if (qual) m_rem = 2;
        e.v   = v && !(cfg_zen && zc);
        e.f   = (m_rem > 0) || crc_h;
        e.tag = tag;
        if (m_rem > 0) m_rem--;
        queue_q.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) drive_bit(0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: frame error sampled after the falling edge, violation after the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (queue_q.size() > 0) begin
                exp_t e;
                bit   f_s;
                e   = queue_q.pop_front();
                f_s = frm_err_out;
                @(posedge clk);
                #2;
                chk(viol_out, e.v, e.tag, "viol_out");
                chk(f_s, e.f, e.tag, "frm_err_out");
            end
        end
    end

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, cycles = %0d, expected fewer", WDOG_CYC);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: outputs stay low under reset with active inputs
        bit_viol = 1; fbit_stb = 1; fbit_err = 1; frame_idx = 5'd3;
        crc_err = 1; mf_due = 1; esf_mode = 1;
        repeat (3) @(posedge clk);
        #2;
        chk(viol_out, 1'b0, "R9", "viol_out in reset");
        chk(frm_err_out, 1'b0, "R9", "frm_err_out in reset");
        @(negedge clk);
        #2;
        chk(viol_out, 1'b0, "R9", "viol_out in reset");
        chk(frm_err_out, 1'b0, "R9", "frm_err_out in reset");
        @(posedge clk);
        #1;
        bit_viol = 0; fbit_stb = 0; fbit_err = 0; crc_err = 0; mf_due = 0;
        esf_mode = 0; frame_idx = '0;
        rst_n = 1;
        idle(2, "R9");

        // R1: single and back-to-back violations
        drive_bit(1, 0, 0, 0, 0, 0, 0, "R1");
        drive_bit(0, 0, 0, 0, 0, 0, 0, "R1");
        drive_bit(1, 0, 0, 0, 0, 0, 0, "R1");
        drive_bit(1, 0, 0, 0, 0, 0, 0, "R1");
        drive_bit(0, 0, 0, 0, 0, 0, 0, "R1");

        // R2: substitution codes masked only while decoding is on
        cfg_zen = 1;
        drive_bit(1, 1, 0, 0, 0, 0, 0, "R2");
        drive_bit(1, 0, 0, 0, 0, 0, 0, "R2");
        cfg_zen = 0;
        drive_bit(1, 1, 0, 0, 0, 0, 0, "R2");
        idle(1, "R2");

        // R3: two-bit framing pulse, needs the F-bit strobe
        cfg_esf = 0; cfg_skip = 0;
        drive_bit(0, 0, 1, 1, 2, 0, 0, "R3");
        idle(3, "R3");
        drive_bit(0, 0, 0, 1, 2, 0, 0, "R3");
        idle(1, "R3");

        // R4: superframe counts every frame, extended only pattern frames
        drive_bit(0, 0, 1, 1, 5, 0, 0, "R4");
        idle(3, "R4");
        cfg_esf = 1;
        drive_bit(0, 0, 1, 1, 7, 0, 0, "R4");
        idle(3, "R4");
        drive_bit(0, 0, 1, 1, 6, 0, 0, "R4");
        idle(1, "R4");
        drive_bit(0, 0, 1, 1, 23, 0, 0, "R4");
        idle(3, "R4");

        // R5: frame-12 skip option
        cfg_esf = 0; cfg_skip = 1;
        drive_bit(0, 0, 1, 1, 11, 0, 0, "R5");
        idle(1, "R5");
        drive_bit(0, 0, 1, 1, 0, 0, 0, "R5");
        idle(3, "R5");
        cfg_skip = 0;
        drive_bit(0, 0, 1, 1, 11, 0, 0, "R5");
        idle(3, "R5");

        // R6: one-bit CRC6 pulse leading multiframe sync by half a period
        cfg_esf = 1;
        drive_bit(0, 0, 0, 0, 0, 1, 1, "R6");
        #3;
        chk(frm_err_out, 1'b0, "R6", "frm_err_out before falling edge");
        idle(2, "R6");
        drive_bit(0, 0, 0, 0, 0, 1, 0, "R6");
        drive_bit(0, 0, 0, 0, 0, 0, 1, "R6");
        idle(1, "R6");

        // R7: superframe ignores the CRC6 path
        cfg_esf = 0;
        drive_bit(0, 0, 0, 0, 0, 1, 1, "R7");
        idle(1, "R7");

        // R8: framing pulse followed by an adjacent CRC6 pulse
        cfg_esf = 1;
        drive_bit(0, 0, 1, 1, 3, 0, 0, "R8");
        idle(1, "R8");
        drive_bit(0, 0, 0, 0, 0, 1, 1, "R8");
        idle(2, "R8");
        drive_bit(0, 0, 1, 1, 3, 1, 1, "R8");
        idle(3, "R8");

        wait (queue_q.size() == 0);
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule